// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block connects a 16-bit register-mapped host bus to an 8-bit NAND flash device. The host first writes a mode byte whose bits drive the NAND control pins directly: chip enable, command latch, address latch, write-protect release, the ECC path select and the power control pair. It then moves bytes through the data register. A 16-bit data access runs as two back-to-back byte cycles on the NAND bus, low byte first. An 8-bit data access runs as a single cycle and is used for command and address bytes.

Each NAND byte cycle has three phases, each a parameterised number of clocks: a setup phase, a phase with the write or read strobe held low, and a hold phase. The host holds its request until a single-cycle acknowledge returns. For a data access this acknowledge comes only after every byte cycle has finished. A status register reports the synchronised ready/busy pin. On the busy-to-ready transition, an interrupt status bit is latched. That bit raises the interrupt output when the mask register allows it.

Top module: `nand_bridge`

## Requirements
- R1: In reset and on the first cycle after it, chip enable is deasserted (`nand_ce_n`=1), CLE, ALE and `nand_wp_n` are 0, both strobes are high, `nand_io_oe` is 0, and `bus_ack` and `irq` are 0.
- R2: The mode register (byte address 4) drives the pins from the edge that accepts the write. Bit 0 drives CLE, bit 1 drives ALE, bits 3:2 drive `nand_pwr_sel`, bit 4 set pulls `nand_ce_n` low, bits 6:5 drive `nand_ecc_sel`, and bit 7 drives `nand_wp_n`. So 0x95 selects command latch, 0x96 address latch, 0x94 plain data, and 0x00 standby with chip enable released.
- R3: A 16-bit write to the data register (byte address 0, `bus_wide`=1) emits `bus_wdata[7:0]` on the NAND bus first and then `bus_wdata[15:8]`, each with `nand_io_oe` high.
- R4: An 8-bit write to the data register (`bus_wide`=0) emits exactly one NAND cycle carrying `bus_wdata[7:0]`.
- R5: A 16-bit read of the data register returns the first NAND byte in `bus_rdata[7:0]` and the second in bits 15:8. An 8-bit read returns one byte in bits 7:0, with bits 15:8 zero.
- R6: In every byte cycle the active strobe (`nand_we_n` for writes, `nand_re_n` for reads) is low for exactly STROBE_CYC clocks. The two strobes are never low together.
- R7: `bus_ack` is a one-cycle pulse for each accepted request. A register access is acknowledged on the accepting edge. A data access of N bytes is acknowledged N*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+1 edges after the accepting edge.
- R8: Reading status (byte address 5) returns bit 7 = 1 while the synchronised `nand_rb` is low (busy), and 0 otherwise. All other bits read 0.
- R9: A low-to-high transition of `nand_rb` sets interrupt status bit 0 (byte address 6) three edges after it is first sampled. Writing a 1 to any of bits 3:0 clears that bit. Writing 0 leaves it. A set in the same cycle wins over a clear.
- R10: `irq` equals mask bit 7 AND the OR of (status bits 3:0 AND mask bits 3:0), registered one cycle. Mask 0x81 enables the ready request; 0x00 or 0x01 keeps `irq` low.
- R11: Byte addresses 1 to 3 read as zero, and writes to them change no register.
- R12: The mode and mask registers read back the last value written, in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid from the acknowledge |
| bus_ack | output | 1 | One-cycle completion pulse |
| nand_io_out | output | 8 | NAND data bus, outgoing |
| nand_io_oe | output | 1 | Output enable for the NAND data bus |
| nand_io_in | input | 8 | NAND data bus, incoming |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write-protect release |
| nand_ecc_sel | output | 2 | ECC path select |
| nand_pwr_sel | output | 2 | Power control pair |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |
| irq | output | 1 | Interrupt request |

## Verification
Pin values from the mode register are due right after the edge that accepts the write. `irq` is due one edge after the status or mask value that justifies it, and a ready edge reaches the status bit three edges after the pin is first sampled. A reference model in the bench advances at every rising edge from the bench's own stimulus and the `nand_rb` history. It is compared with the acknowledge, pin and interrupt outputs at every falling edge, so each result is checked in exactly the cycle it is due. Bus transactions also count the edges from request to acknowledge against 1 or N*(SETUP_CYC+STROBE_CYC+HOLD_CYC)+2. A NAND-side monitor measures each strobe's low time and logs the bytes in the order they appear on the bus.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_MODE = 3'd4;
  localparam logic [2:0] ADR_STAT = 3'd5;
  localparam logic [2:0] ADR_ISR  = 3'd6;
  localparam logic [2:0] ADR_MASK = 3'd7;

  localparam int unsigned MB_CLE = 0;
  localparam int unsigned MB_ALE = 1;
  localparam int unsigned MB_PWR = 2;
  localparam int unsigned MB_CE  = 4;
  localparam int unsigned MB_ECC = 5;
  localparam int unsigned MB_WP  = 7;

endpackage

// File: rtl/nand_bridge_seq.sv
module nand_bridge_seq
  import nand_bridge_pkg::*;
#(
  parameter int unsigned NAND_W     = 8,
  parameter int unsigned LANES      = 2,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     is_write,
  input  logic                     wide,
  input  logic [LANES*NAND_W-1:0]  wdata,
  input  logic [NAND_W-1:0]        io_in,
  output logic                     busy,
  output logic                     done,
  output logic [LANES*NAND_W-1:0]  rdata,
  output logic [NAND_W-1:0]        io_out,
  output logic                     io_oe,
  output logic                     we_n,
  output logic                     re_n
);

  localparam int unsigned WORD_W = LANES * NAND_W;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned MAX_SP = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned MAX_C  = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
  localparam int unsigned CNT_W  = $clog2(MAX_C + 1);

  phase_t              phase;
  logic [CNT_W-1:0]    cnt;
  logic [LANE_W-1:0]   lane;
  logic [LANE_W-1:0]   last;
  logic                dir_wr;
  logic [WORD_W-1:0]   wr_q;
  logic [WORD_W-1:0]   wr_shift;
  logic                ph_end;
  logic                strobe_end;

  assign wr_shift   = wr_q >> NAND_W;
  assign busy       = (phase != PH_IDLE);
  assign strobe_end = (phase == PH_STROBE) && ph_end;

  always_comb begin
    unique case (phase)
      PH_SETUP:  ph_end = (cnt == CNT_W'(SETUP_CYC - 1));
      PH_STROBE: ph_end = (cnt == CNT_W'(STROBE_CYC - 1));
      PH_HOLD:   ph_end = (cnt == CNT_W'(HOLD_CYC - 1));
      default:   ph_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      lane   <= '0;
      last   <= '0;
      dir_wr <= 1'b0;
      wr_q   <= '0;
      io_out <= '0;
      io_oe  <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase  <= PH_SETUP;
          cnt    <= '0;
          lane   <= '0;
          last   <= wide ? LANE_W'(LANES - 1) : '0;
          dir_wr <= is_write;
          wr_q   <= wdata;
          io_out <= wdata[NAND_W-1:0];
          io_oe  <= is_write;
        end
      end else begin
        cnt <= ph_end ? '0 : cnt + 1'b1;
        if (ph_end) begin
          unique case (phase)
            PH_SETUP: begin
              phase <= PH_STROBE;
              if (dir_wr) we_n <= 1'b0;
              else        re_n <= 1'b0;
            end
            PH_STROBE: begin
              phase <= PH_HOLD;
              we_n  <= 1'b1;
              re_n  <= 1'b1;
            end
            PH_HOLD: begin
              if (lane == last) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
                io_oe <= 1'b0;
              end else begin
                phase  <= PH_SETUP;
                lane   <= lane + 1'b1;
                wr_q   <= wr_shift;
                io_out <= wr_shift[NAND_W-1:0];
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NAND_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= '0;
      end else if (phase == PH_IDLE && start) begin
        byte_q <= '0;
      end else if (strobe_end && !dir_wr && lane == LANE_W'(g)) begin
        byte_q <= io_in;
      end
    end
    assign rdata[g*NAND_W +: NAND_W] = byte_q;
  end

  p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  p_write_drives_bus_r3: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> io_oe);

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_strobes_high_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (we_n && re_n));

endmodule

// File: rtl/nand_bridge_regs.sv
module nand_bridge_regs
  import nand_bridge_pkg::*;
#(
  parameter int unsigned ISR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rb_in,
  output logic [7:0]       mode_q,
  output logic [7:0]       mask_q,
  output logic [ISR_W-1:0] isr_q,
  output logic             busy_s,
  output logic             irq_o
);

  logic             rb_m;
  logic             rb_s;
  logic             rb_d;
  logic             rdy_edge;
  logic [ISR_W-1:0] isr_set;
  logic [ISR_W-1:0] isr_clr;

  assign rdy_edge = rb_s && !rb_d;
  assign busy_s   = !rb_s;
  assign isr_set  = {{(ISR_W-1){1'b0}}, rdy_edge};
  assign isr_clr  = (wr_en && wr_addr == ADR_ISR) ? wr_data[ISR_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_m <= 1'b1;
      rb_s <= 1'b1;
      rb_d <= 1'b1;
    end else begin
      rb_m <= rb_in;
      rb_s <= rb_m;
      rb_d <= rb_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADR_MODE) mode_q <= wr_data;
      if (wr_en && wr_addr == ADR_MASK) mask_q <= wr_data;
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      irq_o <= mask_q[7] && |(isr_q & mask_q[ISR_W-1:0]);
    end
  end

  p_ready_edge_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (rb_s && !rb_d) |=> isr_q[0]);

  p_isr_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    (!isr_q[0] && !(rb_s && !rb_d)) |=> !isr_q[0]);

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    !mask_q[7] |=> !irq_o);

endmodule

// File: rtl/nand_bridge.sv
module nand_bridge
  import nand_bridge_pkg::*;
#(
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned NAND_W     = 8,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned ISR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_wide,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic [NAND_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [NAND_W-1:0] nand_io_in,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_wp_n,
  output logic [1:0]        nand_ecc_sel,
  output logic [1:0]        nand_pwr_sel,
  input  logic              nand_rb,
  output logic              irq
);

  localparam int unsigned LANES = BUS_W / NAND_W;

  logic             accept;
  logic             is_data;
  logic             reg_wr;
  logic             seq_busy;
  logic             seq_done;
  logic [BUS_W-1:0] seq_rdata;
  logic [7:0]       mode_q;
  logic [7:0]       mask_q;
  logic [ISR_W-1:0] isr_q;
  logic             busy_s;
  logic             ack_q;
  logic [BUS_W-1:0] rdata_q;
  logic [BUS_W-1:0] reg_rdata;

  assign is_data = (bus_addr == ADR_DATA);
  assign accept  = bus_req && !ack_q && !seq_busy && !seq_done;
  assign reg_wr  = accept && !is_data && bus_we;

  nand_bridge_seq #(
    .NAND_W    (NAND_W),
    .LANES     (LANES),
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept && is_data),
    .is_write(bus_we),
    .wide    (bus_wide),
    .wdata   (bus_wdata),
    .io_in   (nand_io_in),
    .busy    (seq_busy),
    .done    (seq_done),
    .rdata   (seq_rdata),
    .io_out  (nand_io_out),
    .io_oe   (nand_io_oe),
    .we_n    (nand_we_n),
    .re_n    (nand_re_n)
  );

  nand_bridge_regs #(
    .ISR_W(ISR_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .wr_addr(bus_addr),
    .wr_data(bus_wdata[7:0]),
    .rb_in  (nand_rb),
    .mode_q (mode_q),
    .mask_q (mask_q),
    .isr_q  (isr_q),
    .busy_s (busy_s),
    .irq_o  (irq)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_MODE: reg_rdata = {{(BUS_W-8){1'b0}}, mode_q};
      ADR_STAT: reg_rdata = {{(BUS_W-8){1'b0}}, busy_s, 7'b0};
      ADR_ISR:  reg_rdata = {{(BUS_W-ISR_W){1'b0}}, isr_q};
      ADR_MASK: reg_rdata = {{(BUS_W-8){1'b0}}, mask_q};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= (accept && !is_data) || seq_done;
      if (accept && !is_data && !bus_we) rdata_q <= reg_rdata;
      else if (seq_done)                 rdata_q <= seq_rdata;
    end
  end

  assign bus_ack      = ack_q;
  assign bus_rdata    = rdata_q;
  assign nand_ce_n    = !mode_q[MB_CE];
  assign nand_cle     = mode_q[MB_CLE];
  assign nand_ale     = mode_q[MB_ALE];
  assign nand_wp_n    = mode_q[MB_WP];
  assign nand_ecc_sel = mode_q[MB_ECC +: 2];
  assign nand_pwr_sel = mode_q[MB_PWR +: 2];

  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    seq_busy |=> $stable(mode_q));

  p_ce_follows_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (nand_io_oe && !nand_we_n) |-> $stable(nand_ce_n));

endmodule

// File: tb/nand_bridge_test.sv
`timescale 1ns/1ps
module nand_bridge_test;

  localparam int S = 1;
  localparam int P = 2;
  localparam int H = 1;
  localparam int T = S + P + H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_wide = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic [7:0]  nand_io_out;
  logic        nand_io_oe;
  logic [7:0]  nand_io_in = 8'h0;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
  logic [1:0]  nand_ecc_sel, nand_pwr_sel;
  logic        nand_rb = 1'b1;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nand_bridge #(.SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .nand_ecc_sel(nand_ecc_sel), .nand_pwr_sel(nand_pwr_sel), .nand_rb(nand_rb), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, advanced at every rising edge
  logic [7:0] m_mode, m_mask;
  logic [3:0] m_isr;
  logic       m_irq, m_ack;
  int         m_cnt;
  logic       rbh0, rbh1, rbh2;

  always @(posedge clk) begin
    logic [3:0] clr;
    logic       set0;
    if (rst) begin
      m_mode = 0; m_mask = 0; m_isr = 0; m_irq = 0; m_ack = 0; m_cnt = 0;
      rbh0 = 1; rbh1 = 1; rbh2 = 1;
    end else begin
      clr  = 4'h0;
      set0 = rbh1 & ~rbh2;
      m_irq = m_mask[7] & (|(m_isr & m_mask[3:0]));
      if (m_cnt != 0) begin
        m_ack = (m_cnt == 1);
        m_cnt = m_cnt - 1;
      end else if (bus_req && !m_ack) begin
        if (bus_addr == 3'd0) begin
          m_ack = 0;
          m_cnt = (bus_wide ? 2 : 1) * T + 1;
        end else begin
          m_ack = 1;
          if (bus_we) begin
            if (bus_addr == 3'd4) m_mode = bus_wdata[7:0];
            if (bus_addr == 3'd7) m_mask = bus_wdata[7:0];
            if (bus_addr == 3'd6) clr = bus_wdata[3:0];
          end
        end
      end else begin
        m_ack = 0;
      end
      m_isr = (m_isr & ~clr) | {3'b0, set0};
      rbh2 = rbh1; rbh1 = rbh0; rbh0 = nand_rb;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({nand_ce_n, nand_cle, nand_ale, nand_wp_n, nand_ecc_sel, nand_pwr_sel} ==
          {~m_mode[4], m_mode[0], m_mode[1], m_mode[7], m_mode[6:5], m_mode[3:2]},
          "R2", "pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n, nand_ecc_sel, nand_pwr_sel},
          {~m_mode[4], m_mode[0], m_mode[1], m_mode[7], m_mode[6:5], m_mode[3:2]});
      chk(bus_ack == m_ack, "R7", "ack", bus_ack, m_ack);
      chk(irq == m_irq, "R10", "irq", irq, m_irq);
      chk(!(!nand_we_n && !nand_re_n), "R6", "strobe overlap", {nand_we_n, nand_re_n}, 2'b11);
    end
  end

  // NAND-side monitor: strobe widths and written bytes
  logic [7:0] wr_log[$];
  int we_lo = 0, re_lo = 0;
  logic we_prev = 1, re_prev = 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!nand_we_n) we_lo++;
      else if (!we_prev) begin
        chk(we_lo == P, "R6", "we width", we_lo, P);
        chk(nand_io_oe == 1'b1, "R3", "oe in hold", nand_io_oe, 1);
        wr_log.push_back(nand_io_out);
        we_lo = 0;
      end
      if (!nand_re_n) re_lo++;
      else if (!re_prev) begin
        chk(re_lo == P, "R6", "re width", re_lo, P);
        re_lo = 0;
      end
      we_prev = nand_we_n;
      re_prev = nand_re_n;
    end
  end

  logic [7:0] rd_src[$];

  task automatic bus_op(input logic we, input logic wide, input logic [2:0] addr,
                        input logic [15:0] wd, input int exp_lat, input string req,
                        output logic [15:0] rd);
    int   lat = 0;
    logic pre = 1'b1;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_wide = wide; bus_addr = addr; bus_wdata = wd;
    forever begin
      @(negedge clk);
      lat++;
      if (!nand_re_n && pre) nand_io_in = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hEE;
      pre = nand_re_n;
      if (bus_ack || lat > 500) break;
    end
    rd = bus_rdata;
    bus_req = 0;
    chk(lat == exp_lat, req, "latency", lat, exp_lat);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] v);
    logic [15:0] d;
    bus_op(1, 0, a, {8'h0, v}, 1, "R7", d);
  endtask

  task automatic rreg(input logic [2:0] a, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_op(0, 0, a, 16'h0, 1, "R7", d);
    chk(d == exp, req, "reg read", d, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({nand_ce_n, nand_cle, nand_ale, nand_wp_n, nand_we_n, nand_re_n, nand_io_oe, bus_ack, irq}
        == 9'b1_0_0_0_1_1_0_0_0, "R1", "reset outputs",
        {nand_ce_n, nand_cle, nand_ale, nand_wp_n, nand_we_n, nand_re_n, nand_io_oe, bus_ack, irq},
        9'b100011000);
    rst = 0;
    @(negedge clk);
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_io_oe, irq} == 5'b11100, "R1", "after reset",
        {nand_ce_n, nand_we_n, nand_re_n, nand_io_oe, irq}, 5'b11100);

    // R2 command latch, R4 single command byte
    wreg(3'd4, 8'h95);
    chk({nand_ce_n, nand_cle, nand_ale} == 3'b010, "R2", "cmd mode pins",
        {nand_ce_n, nand_cle, nand_ale}, 3'b010);
    bus_op(1, 0, 3'd0, 16'hABFF, 1 + T + 1, "R7", d);
    chk(wr_log.size() == 1, "R4", "8-bit write cycles", wr_log.size(), 1);
    if (wr_log.size() > 0) chk(wr_log.pop_front() == 8'hFF, "R4", "cmd byte", 0, 8'hFF);
    wr_log.delete();

    // R2 address latch
    wreg(3'd4, 8'h96);
    chk({nand_ce_n, nand_cle, nand_ale} == 3'b001, "R2", "addr mode pins",
        {nand_ce_n, nand_cle, nand_ale}, 3'b001);
    bus_op(1, 0, 3'd0, 16'h0042, 1 + T + 1, "R7", d);
    chk(wr_log.size() == 1 && wr_log[0] == 8'h42, "R4", "addr byte",
        (wr_log.size() > 0) ? wr_log[0] : 8'h00, 8'h42);
    wr_log.delete();

    // R3 16-bit writes, low byte first
    wreg(3'd4, 8'h94);
    bus_op(1, 1, 3'd0, 16'hA55A, 1 + 2*T + 1, "R7", d);
    bus_op(1, 1, 3'd0, 16'h1234, 1 + 2*T + 1, "R7", d);
    chk(wr_log.size() == 4, "R3", "byte count", wr_log.size(), 4);
    if (wr_log.size() == 4) begin
      chk({wr_log[0], wr_log[1]} == 16'h5AA5, "R3", "order word1", {wr_log[0], wr_log[1]}, 16'h5AA5);
      chk({wr_log[2], wr_log[3]} == 16'h3412, "R3", "order word2", {wr_log[2], wr_log[3]}, 16'h3412);
    end
    wr_log.delete();

    // R5 reads
    rd_src.push_back(8'h3C); rd_src.push_back(8'hC3);
    bus_op(0, 1, 3'd0, 16'h0, 1 + 2*T + 1, "R7", d);
    chk(d == 16'hC33C, "R5", "16-bit read", d, 16'hC33C);
    rd_src.push_back(8'h77);
    bus_op(0, 0, 3'd0, 16'h0, 1 + T + 1, "R7", d);
    chk(d == 16'h0077, "R5", "8-bit read", d, 16'h0077);
    chk(nand_io_oe == 1'b0, "R3", "bus released on read", nand_io_oe, 0);

    // R12 readback, R11 unmapped addresses
    rreg(3'd4, 16'h0094, "R12");
    wreg(3'd7, 8'h81);
    rreg(3'd7, 16'h0081, "R12");
    wreg(3'd2, 8'hFF);
    rreg(3'd4, 16'h0094, "R11");
    rreg(3'd7, 16'h0081, "R11");
    rreg(3'd2, 16'h0000, "R11");

    // R8 status busy, R9/R10 ready edge interrupt
    nand_rb = 0;
    wait_cyc(5);
    rreg(3'd5, 16'h0080, "R8");
    chk(irq == 1'b0, "R10", "no irq while busy", irq, 0);
    nand_rb = 1;
    wait_cyc(6);
    rreg(3'd5, 16'h0000, "R8");
    chk(irq == 1'b1, "R10", "irq after ready", irq, 1);
    rreg(3'd6, 16'h0001, "R9");
    wreg(3'd6, 8'h0E);
    rreg(3'd6, 16'h0001, "R9");
    wreg(3'd6, 8'h0F);
    rreg(3'd6, 16'h0000, "R9");
    wait_cyc(2);
    chk(irq == 1'b0, "R10", "irq cleared", irq, 0);

    // R10 mask without master enable
    wreg(3'd7, 8'h01);
    nand_rb = 0; wait_cyc(4); nand_rb = 1; wait_cyc(6);
    rreg(3'd6, 16'h0001, "R9");
    chk(irq == 1'b0, "R10", "mask 0x01 holds irq low", irq, 0);
    wreg(3'd7, 8'h81);
    wait_cyc(2);
    chk(irq == 1'b1, "R10", "mask 0x81 raises irq", irq, 1);
    wreg(3'd7, 8'h00);
    wait_cyc(2);
    chk(irq == 1'b0, "R10", "mask 0x00 drops irq", irq, 0);

    // R2 standby
    wreg(3'd4, 8'h00);
    chk({nand_ce_n, nand_cle, nand_ale, nand_wp_n} == 4'b1000, "R2", "standby pins",
        {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b1000);
    wreg(3'd4, 8'h6C);
    chk({nand_ecc_sel, nand_pwr_sel} == 4'b1111, "R2", "ecc/pwr pins",
        {nand_ecc_sel, nand_pwr_sel}, 4'b1111);

    wait_cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule